// File: doc/BRIEF.md
# Two-Section Decade Counter

This block is a four-bit BCD counter made from two sections that can run on their own or be joined. The low section is a divide-by-two stage that owns bit 0. The high section is a divide-by-five stage that owns bits 3 to 1. Each section has its own count-enable pulse. These pulses take the place of the separate ripple clocks that such a counter would use, and every flop runs on the one system clock.

When `chain_en` is high, the high section steps each time the low section wraps from 1 to 0. The four bits then run through the decimal digits 0 to 9 and wrap to 0. Two gated force inputs act on the counter: one pair clears it to zero and the other pair presets it to nine. The terminal-count output can drive the low-section enable of the next decade, so three stacked units divide an event stream by 1000.

Every port carries a plain level or a one-cycle pulse. The block has no data stream, so it has no valid/ready handshake and no back-pressure.

Top module: `decade_counter_top`

## Requirements
- R1: While `rst_n` is low, `count` is 0000 and `tc` is 0. After release, the counter holds 0000 until an enable or force input is applied.
- R2: A cycle with `tick_lo` high and no force toggles bit 0 at the next rising clock edge. A cycle with no enable and no force leaves `count` unchanged.
- R3: With `chain_en` low, each `tick_hi` pulse steps bits 3:1 through 0,1,2,3,4 and then back to 0. Bit 0 is not affected.
- R4: With `chain_en` high, bits 3:1 step when `tick_lo` is high and bit 0 is 1, and `tick_hi` is ignored. Repeated `tick_lo` pulses then give `count` values 0 through 9 (1001) and then 0000.
- R5: When `zero_a` and `zero_b` are both high, `count` becomes 0000 at the next edge. Either one alone has no effect.
- R6: When `nine_a` and `nine_b` are both high, `count` becomes 1001 at the next edge. Either one alone has no effect.
- R7: A preset to nine wins over a simultaneous clear to zero.
- R8: A force to zero or to nine overrides any enable pulse given in the same cycle.
- R9: `tc` is high exactly when `count` is 1001, `chain_en` is high and `tick_lo` is high. It is combinational from those inputs and the current count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| tick_lo | input | 1 | Count enable of the divide-by-two section |
| tick_hi | input | 1 | Count enable of the divide-by-five section (unchained mode) |
| chain_en | input | 1 | Joins the sections so the pair counts decimal digits |
| zero_a | input | 1 | Clear-to-zero gate, first input |
| zero_b | input | 1 | Clear-to-zero gate, second input |
| nine_a | input | 1 | Preset-to-nine gate, first input |
| nine_b | input | 1 | Preset-to-nine gate, second input |
| count | output | 4 | BCD count, bit 0 from the low section |
| tc | output | 1 | Terminal count, carry enable for the next decade |

## Verification
The bench targets these corner cases:

- **Wrap points.** It checks the 9-to-0 step in chained mode and the 4-to-0 step of the high section alone. A high section that let a mis-sized compare through would show 10 or a stray upper code instead of 0.
- **Gated forces.** It drives each force input with only one of its pair high. A design that ORed the pair instead of ANDing it would clear or preset the count there.
- **Force priority.** It drives clear and preset together, and it drives a force together with an enable. A wrong priority shows up as 0000 instead of 1001, or as a count that moves past the forced value.
- **Terminal count.** It samples `tc` at nine with and without chaining, and at other counts. A flag that ignored the enable or the mode would carry into the next decade at the wrong time.

// File: rtl/dc_pkg.sv
package dc_pkg;
  typedef enum logic [1:0] {
    FRC_NONE = 2'd0,
    FRC_ZERO = 2'd1,
    FRC_NINE = 2'd2
  } force_e;
endpackage

// File: rtl/dc_force_decode.sv
module dc_force_decode
  import dc_pkg::*;
(
  input  logic   zero_a,
  input  logic   zero_b,
  input  logic   nine_a,
  input  logic   nine_b,
  output force_e frc
);
  always_comb begin
    if (nine_a && nine_b)      frc = FRC_NINE;   // preset wins (R7)
    else if (zero_a && zero_b) frc = FRC_ZERO;
    else                       frc = FRC_NONE;
  end
endmodule

// File: rtl/dc_div2_stage.sv
module dc_div2_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic load,
  input  logic load_val,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= 1'b0;
    else if (load) q <= load_val;
    else if (en)   q <= ~q;
  end

  p_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !load) |=> (q != $past(q)));
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !load) |=> $stable(q));
  p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (q == $past(load_val)));
endmodule

// File: rtl/dc_divn_stage.sv
module dc_divn_stage #(
  parameter int MOD = 5,
  localparam int W  = (MOD > 1) ? $clog2(MOD) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] LAST = W'(MOD - 1);

  logic [W-1:0] q_next;
  // Codes at or above LAST fold back to zero.
  always_comb q_next = (q >= LAST) ? '0 : q + W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= load_val;
    else if (en)   q <= q_next;
  end

  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !load && q == LAST) |=> (q == '0));
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !load && q < LAST) |=> (q == $past(q) + W'(1)));
  p_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !load) |=> $stable(q));
endmodule

// File: rtl/decade_counter_top.sv
module decade_counter_top
  import dc_pkg::*;
#(
  parameter int HI_MOD = 5,
  localparam int HI_W  = $clog2(HI_MOD),
  localparam int CW    = HI_W + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_lo,
  input  logic          tick_hi,
  input  logic          chain_en,
  input  logic          zero_a,
  input  logic          zero_b,
  input  logic          nine_a,
  input  logic          nine_b,
  output logic [CW-1:0] count,
  output logic          tc
);
  localparam logic [HI_W-1:0] HI_TOP = HI_W'(HI_MOD - 1);
  localparam logic [CW-1:0]   TERM   = {HI_TOP, 1'b1};

  force_e          frc;
  logic            lo_q;
  logic [HI_W-1:0] hi_q;
  logic            hi_en;
  logic            do_load;
  logic            lo_ld;
  logic [HI_W-1:0] hi_ld;

  dc_force_decode u_frc (
    .zero_a(zero_a), .zero_b(zero_b),
    .nine_a(nine_a), .nine_b(nine_b),
    .frc(frc)
  );

  always_comb begin
    do_load = (frc != FRC_NONE);
    lo_ld   = (frc == FRC_NINE);
    hi_ld   = (frc == FRC_NINE) ? HI_TOP : '0;
    // Chained: high section steps when the low bit wraps 1 -> 0.
    hi_en   = chain_en ? (tick_lo && lo_q) : tick_hi;
  end

  dc_div2_stage u_lo (
    .clk(clk), .rst_n(rst_n), .en(tick_lo),
    .load(do_load), .load_val(lo_ld), .q(lo_q)
  );

  dc_divn_stage #(.MOD(HI_MOD)) u_hi (
    .clk(clk), .rst_n(rst_n), .en(hi_en),
    .load(do_load), .load_val(hi_ld), .q(hi_q)
  );

  assign count = {hi_q, lo_q};
  assign tc    = (count == TERM) && chain_en && tick_lo;

  p_nine_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (nine_a && nine_b) |=> (count == TERM));
  p_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_a && zero_b && !(nine_a && nine_b)) |=> (count == '0));
  p_tc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tc |-> (count == TERM));
  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tc && !zero_a && !nine_a) |=> (count == '0));
endmodule

// File: tb/decade_counter_top_bench.sv
`timescale 1ns/100ps
module decade_counter_top_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_lo = 0, tick_hi = 0, chain_en = 0;
  logic zero_a = 0, zero_b = 0, nine_a = 0, nine_b = 0;
  logic [3:0] count;
  logic tc;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  logic [3:0] exp_q[$];
  string      tag_q[$];
  int ref_lo = 0;
  int ref_hi = 0;

  always #2.5 clk = ~clk;

  decade_counter_top u_decade_counter_top (
    .clk(clk), .rst_n(rst_n), .tick_lo(tick_lo), .tick_hi(tick_hi),
    .chain_en(chain_en), .zero_a(zero_a), .zero_b(zero_b),
    .nine_a(nine_a), .nine_b(nine_b), .count(count), .tc(tc)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Driver: applies one cycle of inputs, checks tc, pushes expected count.
  task automatic step(input string tag, input bit tl, input bit th, input bit ch,
                      input bit za, input bit zb, input bit na, input bit nb);
    int cur;
    int etc;
    int nlo;
    int nhi;
    @(negedge clk);
    tick_lo = tl; tick_hi = th; chain_en = ch;
    zero_a = za; zero_b = zb; nine_a = na; nine_b = nb;
    cur = ref_hi * 2 + ref_lo;
    etc = (cur == 9 && ch && tl) ? 1 : 0;
    nlo = ref_lo; nhi = ref_hi;
    if (na && nb) begin nlo = 1; nhi = 4; end
    else if (za && zb) begin nlo = 0; nhi = 0; end
    else begin
      if (tl) nlo = 1 - ref_lo;
      if (ch ? (tl && ref_lo == 1) : th) nhi = (ref_hi >= 4) ? 0 : ref_hi + 1;
    end
    ref_lo = nlo; ref_hi = nhi;
    exp_q.push_back(4'(nhi * 2 + nlo));
    tag_q.push_back(tag);
    #1;
    chk({tag, " tc"}, int'(tc), etc);
  endtask

  // Monitor: after each edge, compare count with the oldest expectation.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [3:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({t, " count"}, int'(count), int'(e));
      end
    end
  end

  initial begin
    #20000;
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 reset count", int'(count), 0);
    chk("R1 reset tc", int'(tc), 0);
    rst_n = 1'b1;
    step("R1 idle", 0, 0, 0, 0, 0, 0, 0);
    // R2: toggle and hold
    step("R2 tog", 1, 0, 0, 0, 0, 0, 0);
    step("R2 hold", 0, 0, 0, 0, 0, 0, 0);
    step("R2 tog", 1, 0, 0, 0, 0, 0, 0);
    // R3: upper section alone, wrap after 4
    for (int i = 0; i < 6; i++) step("R3 hi", 0, 1, 0, 0, 0, 0, 0);
    step("R3 lo+hi", 1, 1, 0, 0, 0, 0, 0);
    // R6 / R5: single gate inputs have no effect
    step("R6 nine_a only", 0, 0, 0, 0, 0, 1, 0);
    step("R6 nine_b only", 0, 0, 0, 0, 0, 0, 1);
    step("R5 zero_a only", 0, 0, 0, 1, 0, 0, 0);
    step("R5 zero_b only", 0, 0, 0, 0, 1, 0, 0);
    step("R5 clear", 0, 0, 0, 1, 1, 0, 0);
    // R4: chained decade sequence with tick_hi held high (ignored)
    for (int i = 0; i < 12; i++) step("R4 chain", 1, 1, 1, 0, 0, 0, 0);
    step("R4 hold", 0, 1, 1, 0, 0, 0, 0);
    // R6: preset to nine
    step("R6 nine", 0, 0, 0, 0, 0, 1, 1);
    // R9: at nine, tc needs both chain and tick_lo
    step("R9 no chain", 1, 0, 0, 0, 0, 0, 0);
    step("R6 nine again", 0, 0, 0, 0, 0, 1, 1);
    step("R9 no tick", 0, 0, 1, 0, 0, 0, 0);
    step("R9 carry", 1, 0, 1, 0, 0, 0, 0);
    // R7: preset beats clear
    step("R7 both", 0, 0, 0, 1, 1, 1, 1);
    // R8: force beats enables
    step("R8 clear+tick", 1, 1, 1, 1, 1, 0, 0);
    step("R8 nine+tick", 1, 1, 1, 0, 0, 1, 1);
    step("R8 nine+tick tc", 1, 0, 1, 0, 0, 1, 1);
    step("R4 after nine", 1, 0, 1, 0, 0, 0, 0);
    step("R2 final idle", 0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule